// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Controller

This block gathers seven interrupt sources of an SPI controller into one status vector, qualifies that vector with an interrupt mask, and drives a single registered interrupt line. Three sources are one-cycle event pulses: receive overflow, mode fault and transmit underflow. Each pulse sets a sticky status bit, and software clears that bit by writing a one to it. The other four sources are FIFO fill conditions. Their status bits are registered copies of the level inputs and are refreshed on every clock.

The mask has no direct write path. Software sets mask bits through a write-one-to-set port and clears them through a separate write-one-to-clear port. The mask can be read back on its own output. Each write port is a plain strobe with a data word. There is no stream data path, so no valid/ready handshake exists and nothing can apply back-pressure. A strobe is accepted in the cycle it is high.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Status and mask bit positions are: 0 receive overflow, 1 mode fault, 2 transmit not full, 3 transmit full, 4 receive not empty, 5 receive full, 6 transmit underflow.
- R2: A one-cycle pulse on an event input (bits 0, 1, 6) sets the matching status bit on the next clock. The bit stays set until it is cleared.
- R3: A status write with a one in an event bit clears that bit on the next clock. A zero in that position leaves the bit unchanged.
- R4: When an event pulse and a clearing status write hit the same bit in the same cycle, the bit remains set.
- R5: Status bits 2 to 5 equal their level inputs as registered on the previous clock. Status writes have no effect on these bits.
- R6: A mask-set write with a one in a bit sets that mask bit on the next clock. Zeros leave the mask unchanged.
- R7: A mask-clear write with a one in a bit clears that mask bit on the next clock. Zeros leave the mask unchanged.
- R8: When a mask-set write and a mask-clear write name the same bit in the same cycle, the bit ends up cleared.
- R9: irq_o is high one clock after any bit is high in both status and mask, and low one clock after no such bit exists.
- R10: After reset, status, mask and irq_o are all zero.
- R11: Status writes never change the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_wr | input | 1 | Status write strobe (write-one-to-clear) |
| stat_wdata | input | 7 | Status write data |
| mset_wr | input | 1 | Mask-set write strobe |
| mset_wdata | input | 7 | Mask-set data; ones set mask bits |
| mclr_wr | input | 1 | Mask-clear write strobe |
| mclr_wdata | input | 7 | Mask-clear data; ones clear mask bits |
| ev_rx_ovf | input | 1 | Receive overflow pulse |
| ev_mode_fault | input | 1 | Mode fault pulse |
| ev_tx_udf | input | 1 | Transmit underflow pulse |
| lv_tx_not_full | input | 1 | Transmit FIFO not full level |
| lv_tx_full | input | 1 | Transmit FIFO full level |
| lv_rx_not_empty | input | 1 | Receive FIFO not empty level |
| lv_rx_full | input | 1 | Receive FIFO full level |
| status_o | output | 7 | Current status vector |
| mask_o | output | 7 | Current mask vector (read-only view) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Status and mask change on the first clock edge after the input or write that causes the change. irq_o follows one edge later, two edges after the triggering event or write. The bench drives inputs on the falling edge. At each rising edge it advances a reference model built from the requirements. It compares all three outputs on the next falling edge, which is exactly one edge after the stimulus. Because of this, the two-edge irq latency appears as the model's irq tracking the model's previous status and mask.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned NSRC = 7;
  localparam int unsigned B_RX_OVF     = 0;
  localparam int unsigned B_MODE_FAULT = 1;
  localparam int unsigned B_TX_NFULL   = 2;
  localparam int unsigned B_TX_FULL    = 3;
  localparam int unsigned B_RX_NEMPTY  = 4;
  localparam int unsigned B_RX_FULL    = 5;
  localparam int unsigned B_TX_UDF     = 6;
  // ones mark sources that follow a level input instead of latching
  localparam logic [NSRC-1:0] LEVEL_MAP = 7'b0111100;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_src_status.sv
module irq_src_status #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] LEVEL_MAP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] status
);
  localparam logic [W-1:0] STICKY = ~LEVEL_MAP;
  logic [W-1:0] clr_vec;

  always_comb clr_vec = clr_wr ? clr_data : '0;

  // sticky bits hold unless cleared; a fresh source pulse always wins
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= src | (status & STICKY & ~clr_vec);
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic [W-1:0] set_data,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] mask
);
  logic [W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec = set_wr ? set_data : '0;
    clr_vec = clr_wr ? clr_data : '0;
  end

  // clear applied after set: clear wins on a collision
  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else        mask <= (mask | set_vec) & ~clr_vec;
  end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status & mask);
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_wr,
  input  logic [NSRC-1:0] stat_wdata,
  input  logic            mset_wr,
  input  logic [NSRC-1:0] mset_wdata,
  input  logic            mclr_wr,
  input  logic [NSRC-1:0] mclr_wdata,
  input  logic            ev_rx_ovf,
  input  logic            ev_mode_fault,
  input  logic            ev_tx_udf,
  input  logic            lv_tx_not_full,
  input  logic            lv_tx_full,
  input  logic            lv_rx_not_empty,
  input  logic            lv_rx_full,
  output logic [NSRC-1:0] status_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  src_vec_t src_vec;

  always_comb begin
    src_vec               = '0;
    src_vec[B_RX_OVF]     = ev_rx_ovf;
    src_vec[B_MODE_FAULT] = ev_mode_fault;
    src_vec[B_TX_NFULL]   = lv_tx_not_full;
    src_vec[B_TX_FULL]    = lv_tx_full;
    src_vec[B_RX_NEMPTY]  = lv_rx_not_empty;
    src_vec[B_RX_FULL]    = lv_rx_full;
    src_vec[B_TX_UDF]     = ev_tx_udf;
  end

  irq_src_status #(.W(NSRC), .LEVEL_MAP(LEVEL_MAP)) u_status (
    .clk(clk), .rst_n(rst_n), .src(src_vec),
    .clr_wr(stat_wr), .clr_data(stat_wdata), .status(status_o)
  );

  irq_mask_reg #(.W(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_wr(mset_wr), .set_data(mset_wdata),
    .clr_wr(mclr_wr), .clr_data(mclr_wdata), .mask(mask_o)
  );

  irq_out_reg #(.W(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .status(status_o), .mask(mask_o), .irq(irq_o)
  );
endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
  import spi_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            stat_wr,
  input logic [NSRC-1:0] stat_wdata,
  input logic            mset_wr,
  input logic [NSRC-1:0] mset_wdata,
  input logic            mclr_wr,
  input logic [NSRC-1:0] mclr_wdata,
  input logic            ev_rx_ovf,
  input logic            ev_mode_fault,
  input logic            ev_tx_udf,
  input logic            lv_tx_not_full,
  input logic            lv_tx_full,
  input logic            lv_rx_not_empty,
  input logic            lv_rx_full,
  input logic [NSRC-1:0] status_o,
  input logic [NSRC-1:0] mask_o,
  input logic            irq_o
);
  localparam logic [NSRC-1:0] EVB = ~LEVEL_MAP;
  logic [NSRC-1:0] evv, lvv, clrv, setm, clrm;

  always_comb begin
    evv  = {ev_tx_udf, 4'b0, ev_mode_fault, ev_rx_ovf};
    lvv  = {1'b0, lv_rx_full, lv_rx_not_empty, lv_tx_full, lv_tx_not_full, 2'b0};
    clrv = stat_wr ? stat_wdata : '0;
    setm = mset_wr ? mset_wdata : '0;
    clrm = mclr_wr ? mclr_wdata : '0;
  end

  p_evt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(evv)) == $past(evv)));
  p_evt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(status_o & EVB & ~clrv)) == $past(status_o & EVB & ~clrv)));
  p_evt_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & $past(clrv & EVB & ~evv)) == '0));
  p_lvl_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & LEVEL_MAP) == $past(lvv)));
  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_o & $past(setm & ~clrm)) == $past(setm & ~clrm)));
  p_mask_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((mask_o & $past(clrm)) == '0));
  p_mask_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mset_wr && !mclr_wr |=> $stable(mask_o));
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status_o & mask_o))));
endmodule

bind spi_irq_ctrl spi_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
  .mset_wr(mset_wr), .mset_wdata(mset_wdata), .mclr_wr(mclr_wr), .mclr_wdata(mclr_wdata),
  .ev_rx_ovf(ev_rx_ovf), .ev_mode_fault(ev_mode_fault), .ev_tx_udf(ev_tx_udf),
  .lv_tx_not_full(lv_tx_not_full), .lv_tx_full(lv_tx_full),
  .lv_rx_not_empty(lv_rx_not_empty), .lv_rx_full(lv_rx_full),
  .status_o(status_o), .mask_o(mask_o), .irq_o(irq_o)
);

// File: tb/sim_spi_irq_ctrl.sv
`timescale 1ns/1ps
module sim_spi_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stat_wr = 1'b0, mset_wr = 1'b0, mclr_wr = 1'b0;
  logic [6:0] stat_wdata = '0, mset_wdata = '0, mclr_wdata = '0;
  logic ev_rx_ovf = 1'b0, ev_mode_fault = 1'b0, ev_tx_udf = 1'b0;
  logic lv_tx_not_full = 1'b0, lv_tx_full = 1'b0, lv_rx_not_empty = 1'b0, lv_rx_full = 1'b0;
  logic [6:0] status_o, mask_o;
  logic irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [6:0] m_stat = '0, m_mask = '0;
  logic m_irq = 1'b0;

  always #2.5 clk = ~clk;

  spi_irq_ctrl u0 (.*);

  // R1 positions: 0 rx_ovf,1 mode_fault,2 tx_not_full,3 tx_full,4 rx_not_empty,5 rx_full,6 tx_udf
  function automatic logic [6:0] f_src();
    return {ev_tx_udf, lv_rx_full, lv_rx_not_empty, lv_tx_full, lv_tx_not_full,
            ev_mode_fault, ev_rx_ovf};
  endfunction

  function automatic logic [6:0] f_next_stat(logic [6:0] st, logic [6:0] src,
                                             logic wr, logic [6:0] wd);
    logic [6:0] clr = wr ? wd : 7'd0;
    logic [6:0] r;
    for (int b = 0; b < 7; b++) begin
      if (b >= 2 && b <= 5) r[b] = src[b];                 // R5
      else r[b] = src[b] | (st[b] & ~clr[b]);              // R2 R3 R4
    end
    return r;
  endfunction

  function automatic logic [6:0] f_next_mask(logic [6:0] m, logic sw, logic [6:0] sd,
                                             logic cw, logic [6:0] cd);
    logic [6:0] r = m;
    if (sw) r = r | sd;                                    // R6
    if (cw) r = r & ~cd;                                   // R7 R8
    return r;
  endfunction

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // inputs are already driven; advance one edge, update model, compare on falling edge
  task automatic step(string tag);
    @(posedge clk);
    #0.5;
    m_irq  = |(m_stat & m_mask);                           // R9
    m_stat = f_next_stat(m_stat, f_src(), stat_wr, stat_wdata);
    m_mask = f_next_mask(m_mask, mset_wr, mset_wdata, mclr_wr, mclr_wdata);
    @(negedge clk);
    check({tag, " status"}, status_o, m_stat);
    check({tag, " mask"}, mask_o, m_mask);
    check({tag, " irq"}, {6'd0, irq_o}, {6'd0, m_irq});
  endtask

  task automatic idle();
    stat_wr = 0; mset_wr = 0; mclr_wr = 0;
    ev_rx_ovf = 0; ev_mode_fault = 0; ev_tx_udf = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset status", status_o, 7'd0);
    check("R10 reset mask", mask_o, 7'd0);
    check("R10 reset irq", {6'd0, irq_o}, 7'd0);
    rst_n = 1'b1;

    // R1 bit positions of each source
    ev_rx_ovf = 1; step("R1 rx_ovf"); check("R1 bit0", status_o, 7'b0000001); idle();
    stat_wr = 1; stat_wdata = 7'h7F; step("R3 clear all");
    check("R3 cleared", status_o, 7'd0); idle();
    ev_mode_fault = 1; step("R1 mode_fault"); check("R1 bit1", status_o, 7'b0000010); idle();
    ev_tx_udf = 1; step("R2 udf"); check("R1 bit6", status_o, 7'b1000010); idle();
    step("R2 hold"); check("R2 sticky", status_o, 7'b1000010);
    lv_rx_full = 1; step("R5 level"); check("R1 bit5", status_o, 7'b1100010);
    // R5: clearing write ignored on level bit
    stat_wr = 1; stat_wdata = 7'b0100000; step("R5 write ignored");
    check("R5 level kept", status_o, 7'b1100010); idle();
    lv_rx_full = 0; step("R5 level drop"); check("R5 follows", status_o, 7'b1000010);
    // R4 event vs clear
    ev_tx_udf = 1; stat_wr = 1; stat_wdata = 7'b1000000; step("R4 collide");
    check("R4 event wins", status_o, 7'b1000010); idle();
    // R6 / R8 / R11
    mset_wr = 1; mset_wdata = 7'b1000001; step("R6 set"); check("R6 mask", mask_o, 7'b1000001); idle();
    step("R9 irq rise"); check("R9 irq", {6'd0, irq_o}, 7'd1);
    mset_wr = 1; mset_wdata = 7'b0000110; mclr_wr = 1; mclr_wdata = 7'b0000100;
    step("R8 collide"); check("R8 clear wins", mask_o, 7'b1000011); idle();
    stat_wr = 1; stat_wdata = 7'h7F; step("R11 stat write"); check("R11 mask kept", mask_o, 7'b1000011); idle();
    mclr_wr = 1; mclr_wdata = 7'h7F; step("R7 clear"); check("R7 mask", mask_o, 7'd0); idle();
    step("R9 irq fall"); check("R9 irq low", {6'd0, irq_o}, 7'd0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ev_rx_ovf     = ($urandom % 8) == 0;
      ev_mode_fault = ($urandom % 8) == 0;
      ev_tx_udf     = ($urandom % 8) == 0;
      lv_tx_not_full  = $urandom % 2;
      lv_tx_full      = ($urandom % 4) == 0;
      lv_rx_not_empty = $urandom % 2;
      lv_rx_full      = ($urandom % 4) == 0;
      stat_wr = ($urandom % 4) == 0; stat_wdata = 7'($urandom);
      mset_wr = ($urandom % 5) == 0; mset_wdata = 7'($urandom);
      mclr_wr = ($urandom % 5) == 0; mclr_wdata = 7'($urandom);
      step("R2-mix random");
    end
    idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule